// File: doc/BRIEF.md
# Pair-Set Power Delivery Controller

This block is the control state machine that looks after one pair set once the search phase has handed it a valid load. When it gets a start strobe it raises the powered indication. It then watches the inrush phase and moves through a parameter-setting step into steady power. If the equipment can use a data link and the link is not yet on, it takes a short detour to switch the link on. A system with two pair sets uses one instance per pair set.

Every fault goes through an error-delay state. That state drops power and waits for a fixed number of cycles before handing back to idle. A port-voltage-limit detection cuts the wait short. The block also hands back to idle, through a one-cycle return-to-idle strobe, in three other cases:

- the maintain-power timer expires cleanly;
- power is denied;
- the power-on timer expires before the port is ready.

Top module: `pset_power_fsm`

## Requirements
- R1: After reset the block is idle, with `powered_o`, `link_en_o` and `rti_o` all low.
- R2: A `start_i` strobe while idle enters power-up, and `powered_o` is high from the next cycle.
- R3: In power-up, ready-to-power is power applied, the power-on timer not done, and either the inrush timer done or a legacy power-up. When it holds and there is no fault, the block goes through parameter setting into steady power-on in two cycles, and `powered_o` stays high.
- R4: A legacy power-up with the inrush timer still running counts as ready, so steady power-on is reached without the inrush timer finishing.
- R5: In power-up, a done inrush timer with legacy power-up, power not applied, or port current at or above the inrush limit leads to error delay. So does a short, overload or port-voltage-limit detection. Error delay drives `powered_o` low.
- R6: In power-up without ready-to-power and without a fault, a done power-on timer returns to idle. Otherwise the block waits in power-up with `powered_o` high.
- R7: In steady power-on, a short, overload or port-voltage-limit detection enters error delay, ahead of every other exit.
- R8: In steady power-on, a done maintain-power timer with no short, overload, voltage-limit or power-unavailable condition returns to idle.
- R9: In steady power-on, power unavailable with no short, overload or voltage limit, while the maintain-power timer still runs, returns to idle. Power unavailable together with a done maintain-power timer stays in power-on.
- R10: `link_en_o` is set when the block passes through its link-enable step, and it also sets on `peer_link_set_i`. Only reset clears it. The link-enable step is taken from power-on only when `link_cap_i` is high and `link_en_o` is low.
- R11: Error delay lasts exactly ERR_DLY_CYC cycles before idle. A port-voltage-limit detection during error delay returns to idle at the next edge.
- R12: `rti_o` is a one-cycle pulse, high in the first idle cycle after any return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin power-up (from the search phase) |
| inrush_done_i | input | 1 | Inrush timer done |
| legacy_i | input | 1 | Legacy power-up in progress |
| pwr_applied_i | input | 1 | Power is applied to the pair set |
| over_inrush_i | input | 1 | Port current at or above the inrush limit |
| short_i | input | 1 | Short detected |
| ovld_i | input | 1 | Overload detected |
| vlim_i | input | 1 | Port voltage limit detected |
| pwr_unavail_i | input | 1 | Power not available |
| mpdo_done_i | input | 1 | Maintain-power timer done |
| pon_done_i | input | 1 | Power-on timer done |
| link_cap_i | input | 1 | Equipment is data-link capable |
| peer_link_set_i | input | 1 | The other pair-set controller sets the link flag |
| powered_o | output | 1 | Pair set is powered |
| link_en_o | output | 1 | Data link enabled (shared, sticky) |
| rti_o | output | 1 | Return-to-idle strobe |

## Verification
A table of ten condition mixes is applied in steady power-on. Each mix combines short, overload, voltage limit, power unavailable and maintain-power done, and the outcome separates three cases: the fault path (power low, no strobe), a return to idle (power low, strobe), and staying on. The mixes include fault-plus-clean-exit and unavailable-plus-timer-done, which show both the priority of faults and the exclusion terms in the two exit conditions. Directed sequences cover the following:

- the three inrush fault causes, told apart from the legacy path that is accepted while inrush still runs;
- the power-on timeout;
- the exact error-delay length, and its early end on a voltage limit;
- the link flag being set from its own step and from the peer, and surviving everything except reset.

// File: rtl/pset_power_fsm.sv
module pset_power_fsm #(
  parameter int ERR_DLY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic inrush_done_i,
  input  logic legacy_i,
  input  logic pwr_applied_i,
  input  logic over_inrush_i,
  input  logic short_i,
  input  logic ovld_i,
  input  logic vlim_i,
  input  logic pwr_unavail_i,
  input  logic mpdo_done_i,
  input  logic pon_done_i,
  input  logic link_cap_i,
  input  logic peer_link_set_i,
  output logic powered_o,
  output logic link_en_o,
  output logic rti_o
);

  localparam int CW = $clog2(ERR_DLY_CYC + 1);
  localparam logic [CW-1:0] ERR_LAST = CW'(ERR_DLY_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PUP, S_SETP, S_LINK, S_ON, S_ERR
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] err_cnt;
  logic rti_q, link_q;

  logic inrush_fault, hard_fault, ready, denied, mp_ok, err_done;

  assign hard_fault   = short_i | ovld_i | vlim_i;
  assign inrush_fault = inrush_done_i & (legacy_i | ~pwr_applied_i | over_inrush_i);
  assign ready        = pwr_applied_i & ~pon_done_i &
                        ((~inrush_done_i & legacy_i) | inrush_done_i);
  assign denied       = pwr_unavail_i & ~hard_fault & ~mpdo_done_i;
  assign mp_ok        = mpdo_done_i & ~hard_fault & ~pwr_unavail_i;
  assign err_done     = (err_cnt == ERR_LAST);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start_i) nxt = S_PUP;
      S_PUP: begin
        if (inrush_fault | hard_fault) nxt = S_ERR;
        else if (ready)                nxt = S_SETP;
        else if (pon_done_i)           nxt = S_IDLE;
      end
      S_SETP: nxt = S_ON;
      S_ON: begin
        if (hard_fault)                      nxt = S_ERR;
        else if (denied | mp_ok)             nxt = S_IDLE;
        else if (link_cap_i & ~link_q)       nxt = S_LINK;
      end
      S_LINK: nxt = S_ON;
      S_ERR: if (err_done | vlim_i) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      err_cnt <= '0;
      rti_q   <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      st    <= nxt;
      rti_q <= (nxt == S_IDLE) && (st != S_IDLE);
      if (st != S_ERR)    err_cnt <= '0;
      else if (!err_done) err_cnt <= err_cnt + 1'b1;
      if (st == S_LINK || peer_link_set_i) link_q <= 1'b1;
    end
  end

  assign powered_o = (st == S_PUP) || (st == S_SETP) || (st == S_LINK) || (st == S_ON);
  assign link_en_o = link_q;
  assign rti_o     = rti_q;

  a_r2_start_powers: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i) |=> powered_o);

  a_r5_inrush_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUP && inrush_done_i && over_inrush_i) |=> (st == S_ERR && !powered_o));

  a_r6_pon_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUP && pon_done_i && !pwr_applied_i && !inrush_done_i && !hard_fault) |=> rti_o);

  a_r7_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON && hard_fault) |=> (st == S_ERR && !rti_o));

  a_r10_link_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    link_en_o |=> link_en_o);

  a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR && !err_done && !vlim_i) |=> (st == S_ERR));

  a_r11_err_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR && err_done) |=> (st == S_IDLE && rti_o));

  a_r12_rti_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rti_o |=> !rti_o);

endmodule

// File: tb/pset_power_fsm_bench.sv
module pset_power_fsm_bench;

  localparam int ERR_DLY = 8;

  logic clk = 1'b0;
  logic rst_n, start, inrush_done, legacy, applied, over, sh, ov, vl, un, mp, pon, cap, peer;
  logic powered, link_en, rti;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pset_power_fsm #(.ERR_DLY_CYC(ERR_DLY)) u_pset_power_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start), .inrush_done_i(inrush_done),
    .legacy_i(legacy), .pwr_applied_i(applied), .over_inrush_i(over),
    .short_i(sh), .ovld_i(ov), .vlim_i(vl), .pwr_unavail_i(un),
    .mpdo_done_i(mp), .pon_done_i(pon), .link_cap_i(cap),
    .peer_link_set_i(peer), .powered_o(powered), .link_en_o(link_en), .rti_o(rti)
  );

  // {short, ovld, vlim, unavail, mpdo, outcome}: outcome 0 stay, 1 error delay, 2 return to idle
  localparam logic [6:0] VEC [10] = '{
    7'b00000_00, 7'b10000_01, 7'b01000_01, 7'b00100_01, 7'b00010_10,
    7'b00001_10, 7'b00011_00, 7'b10001_01, 7'b10010_01, 7'b00110_01
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    start = 0; inrush_done = 0; legacy = 0; applied = 0; over = 0;
    sh = 0; ov = 0; vl = 0; un = 0; mp = 0; pon = 0; peer = 0;
  endtask

  task automatic go_idle();
    clear_in();
    mp = 1;
    repeat (ERR_DLY + 3) tick();
    mp = 0;
  endtask

  task automatic to_power_on();
    clear_in();
    applied = 1; inrush_done = 1; start = 1;
    tick();
    start = 0;
    tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_in();
    cap = 0;
    rst_n = 0;
    tick(); tick();
    chk("R1 powered", powered, 1'b0);
    chk("R1 link", link_en, 1'b0);
    chk("R1 rti", rti, 1'b0);
    rst_n = 1;
    tick();
    chk("R1 idle powered", powered, 1'b0);

    // table in power-on: R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      to_power_on();
      chk("R3 powered in power-on", powered, 1'b1);
      {sh, ov, vl, un, mp} = VEC[i][6:2];
      tick();
      case (VEC[i][1:0])
        2'd0: begin chk("R9 stay powered", powered, 1'b1); chk("R9 stay no rti", rti, 1'b0); end
        2'd1: begin chk("R7 fault unpowered", powered, 1'b0); chk("R7 fault no rti", rti, 1'b0); end
        default: begin chk("R8 exit unpowered", powered, 1'b0); chk("R8 exit rti", rti, 1'b1); end
      endcase
      go_idle();
    end

    // R2 R3 progression timing with clean maintain-power exit
    clear_in();
    applied = 1; inrush_done = 1; start = 1;
    tick();
    start = 0;
    chk("R2 powered after start", powered, 1'b1);
    tick(); tick();
    mp = 1;
    tick();
    chk("R3 reached power-on in two cycles", rti, 1'b1);
    tick();
    chk("R12 rti single pulse", rti, 1'b0);
    go_idle();

    // R4 legacy while inrush still running
    clear_in();
    applied = 1; legacy = 1; start = 1;
    tick();
    start = 0;
    tick(); tick();
    chk("R4 legacy powered", powered, 1'b1);
    mp = 1;
    tick();
    chk("R4 legacy reached power-on", rti, 1'b1);
    go_idle();

    // R5 inrush fault causes
    for (int c = 0; c < 3; c++) begin
      clear_in();
      inrush_done = 1; applied = (c != 1); over = (c == 2); legacy = (c == 0);
      start = 1;
      tick();
      start = 0;
      chk("R5 powered in power-up", powered, 1'b1);
      tick();
      chk("R5 fault unpowered", powered, 1'b0);
      chk("R5 fault no rti", rti, 1'b0);
      go_idle();
    end

    // R6 wait then power-on timeout
    clear_in();
    start = 1;
    tick();
    start = 0;
    repeat (4) tick();
    chk("R6 waiting powered", powered, 1'b1);
    chk("R6 waiting no rti", rti, 1'b0);
    pon = 1;
    tick();
    chk("R6 timeout rti", rti, 1'b1);
    chk("R6 timeout unpowered", powered, 1'b0);
    go_idle();

    // R11 exact error-delay length
    to_power_on();
    sh = 1;
    tick();
    sh = 0;
    for (int k = 1; k < ERR_DLY; k++) begin
      tick();
      chk("R11 still in error delay", rti, 1'b0);
    end
    tick();
    chk("R11 error delay ends", rti, 1'b1);
    tick();
    chk("R12 rti cleared", rti, 1'b0);
    go_idle();

    // R11 early end on voltage limit
    to_power_on();
    ov = 1;
    tick();
    ov = 0; vl = 1;
    tick();
    vl = 0;
    chk("R11 vlim early exit", rti, 1'b1);
    go_idle();

    // R10 link enable step
    cap = 1;
    to_power_on();
    chk("R10 link low at power-on", link_en, 1'b0);
    tick(); tick();
    chk("R10 link set by step", link_en, 1'b1);
    mp = 1;
    tick();
    chk("R10 back in power-on", rti, 1'b1);
    go_idle();
    chk("R10 link survives idle", link_en, 1'b1);
    to_power_on();
    mp = 1;
    tick();
    chk("R10 no step when enabled", rti, 1'b1);
    go_idle();
    cap = 0;
    rst_n = 0;
    tick();
    rst_n = 1;
    chk("R10 reset clears link", link_en, 1'b0);
    tick();
    peer = 1;
    tick();
    peer = 0;
    chk("R10 peer sets link", link_en, 1'b1);
    repeat (3) tick();
    chk("R10 peer flag sticky", link_en, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule